// File: doc/BRIEF.md
# Mask-Driven Bit Gather/Scatter Unit

This unit rearranges the bits of a 64-bit word under the control of an arbitrary bitmask. Instead of describing a field by a starting position and a width, the caller supplies one mask word whose set bits pick the positions of interest. The mask positions do not need to be contiguous. Three operations share the same operands: gather (pack the selected bits), scatter (spread packed bits out to the selected positions) and split (send the selected bits to the top of the word and the others to the bottom).

A request is presented as a source word, a mask word and a 2-bit operation code, qualified by a valid strobe. The result is computed combinationally and captured in a register. It appears with its own valid flag one clock later. The unit accepts a new request on every cycle.

Top module: `bit_gather_scatter`

## Requirements
- R1: Operation code 2'b00 (gather) places the source bits found at set mask positions into the result starting at bit 0. The bit at the lowest mask position goes to bit 0. Every result bit above the number of set mask bits is 0.
- R2: Operation code 2'b01 (scatter) takes source bits 0, 1, 2 and onward in order and writes them to the set mask positions, from the lowest position to the highest. Every result bit whose mask bit is 0 is 0. Source bits at or above the number of set mask bits have no effect on the result.
- R3: Operation code 2'b10 (split) places the source bits at set mask positions in the most-significant end of the result. It places the source bits at clear mask positions in the least-significant end. Each group keeps the relative order of its bits.
- R4: With an all-zero mask, gather and scatter return 0 and split returns the source word unchanged.
- R5: With an all-ones mask, gather, scatter and split each return the source word unchanged.
- R6: Operation code 2'b11 is reserved and returns a result of 0.
- R7: The result of a request accepted with in_valid high appears on out_result on the following clock edge, and out_valid equals in_valid delayed by one cycle.
- R8: A synchronous active-high reset sets out_valid to 0 and out_result to 0.
- R9: While in_valid is low, out_result keeps its previous value, whatever is driven on in_src, in_mask and in_op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 00 gather, 01 scatter, 10 split, 11 reserved |
| in_src | input | 64 | Source data word |
| in_mask | input | 64 | Selection mask |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 64 | Registered result |

## Verification
The assertions check several properties on every cycle:
- the one-cycle valid timing and the hold of the result while idle;
- the reserved code giving zero, and the reset values;
- limits on each operation's result: a gather never has more set bits than the mask, a scatter never sets a bit outside the mask, and a split keeps the source's count of set bits;
- the exact identities for an all-ones or all-zero mask.

The exact placement and ordering of bits for arbitrary masks can only be shown by the bench. It compares every cycle against an independently written bit-by-bit model, for sparse, dense, contiguous and random masks. The bench also covers scatter inputs whose upper source bits must be ignored, and a reset applied in the middle of traffic.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        BGS_GATHER  = 2'b00,
        BGS_SCATTER = 2'b01,
        BGS_SPLIT   = 2'b10,
        BGS_RSVD    = 2'b11
    } bgs_op_e;

    // Width needed to hold a count from 0 to w inclusive.
    function automatic int count_w(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/bgs_rank.sv
// Exclusive prefix count of a selection vector: rank[i] is the number of
// selected positions strictly below i; total is the overall count.
module bgs_rank #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input  logic [W-1:0]         sel,
    output logic [W-1:0][CW-1:0] rank,
    output logic [CW-1:0]        total
);
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < W; i++) begin
            rank[i] = acc;
            acc     = acc + CW'(sel[i]);
        end
        total = acc;
    end
endmodule

// File: rtl/bgs_pack.sv
// Packs selected data bits into the low end using precomputed ranks.
module bgs_pack #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input  logic [W-1:0]         data,
    input  logic [W-1:0]         sel,
    input  logic [W-1:0][CW-1:0] rank,
    output logic [W-1:0]         packed_out
);
    localparam int AW = $clog2(W);

    always_comb begin
        packed_out = '0;
        for (int i = 0; i < W; i++) begin
            if (sel[i]) packed_out[rank[i][AW-1:0]] = data[i];
        end
    end
endmodule

// File: rtl/bgs_spread.sv
// Spreads low-order data bits out to the selected positions.
module bgs_spread #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input  logic [W-1:0]         data,
    input  logic [W-1:0]         sel,
    input  logic [W-1:0][CW-1:0] rank,
    output logic [W-1:0]         spread_out
);
    localparam int AW = $clog2(W);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            spread_out[i] = sel[i] & data[rank[i][AW-1:0]];
        end
    end
endmodule

// File: rtl/bit_gather_scatter.sv
module bit_gather_scatter
    import bgs_pkg::*;
#(
    parameter int W = bgs_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_src,
    input  logic [W-1:0] in_mask,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    localparam int CW = count_w(W);
    localparam int NG = 2;  // group 0: set mask bits, group 1: clear mask bits

    logic [NG-1:0][W-1:0]         grp_sel;
    logic [NG-1:0][W-1:0][CW-1:0] grp_rank;
    logic [NG-1:0][CW-1:0]        grp_cnt;
    logic [NG-1:0][W-1:0]         grp_packed;

    assign grp_sel[0] = in_mask;
    assign grp_sel[1] = ~in_mask;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        bgs_rank #(.W(W), .CW(CW)) u_rank (
            .sel   (grp_sel[g]),
            .rank  (grp_rank[g]),
            .total (grp_cnt[g])
        );
        bgs_pack #(.W(W), .CW(CW)) u_pack (
            .data       (in_src),
            .sel        (grp_sel[g]),
            .rank       (grp_rank[g]),
            .packed_out (grp_packed[g])
        );
    end

    logic [W-1:0] spread_res;
    bgs_spread #(.W(W), .CW(CW)) u_spread (
        .data       (in_src),
        .sel        (in_mask),
        .rank       (grp_rank[0]),
        .spread_out (spread_res)
    );

    // Split: selected group moved to the top end. A shift by W yields zero.
    logic [CW-1:0] top_shift;
    logic [W-1:0]  split_res;
    assign top_shift = CW'(W) - grp_cnt[0];
    assign split_res = (grp_packed[0] << top_shift) | grp_packed[1];

    bgs_op_e      op_q;
    logic [W-1:0] nxt_result;
    assign op_q = bgs_op_e'(in_op);

    always_comb begin
        unique case (op_q)
            BGS_GATHER:  nxt_result = grp_packed[0];
            BGS_SCATTER: nxt_result = spread_res;
            BGS_SPLIT:   nxt_result = split_res;
            default:     nxt_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= nxt_result;
        end
    end
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   in_op,
    input logic [W-1:0] in_src,
    input logic [W-1:0] in_mask,
    input logic         out_valid,
    input logic [W-1:0] out_result
);
    // R1: a gather never yields more set bits than the mask holds
    p_gather_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00) |=>
            ($countones(out_result) <= $past($countones(in_mask))));

    // R2: a scatter sets no bit outside the mask
    p_scatter_inside_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b01) |=> ((out_result & ~$past(in_mask)) == '0));

    // R3: a split is a permutation, so the count of ones is kept
    p_split_weight_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10) |=>
            ($countones(out_result) == $past($countones(in_src))));

    // R4: zero mask split returns the source
    p_split_zero_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10 && in_mask == '0) |=> (out_result == $past(in_src)));

    // R5: full mask gather returns the source
    p_gather_full_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00 && (&in_mask)) |=> (out_result == $past(in_src)));

    // R6: reserved code gives zero
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b11) |=> (out_result == '0));

    // R7: valid timing
    p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: reset values
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    // R9: result holds while idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
endmodule

bind bit_gather_scatter bgs_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_src     (in_src),
    .in_mask    (in_mask),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/sim_bit_gather_scatter.sv
`timescale 1ns/1ps
module sim_bit_gather_scatter;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = 2'b00;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] in_mask = '0;
    logic         out_valid;
    logic [W-1:0] out_result;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_gather_scatter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .in_mask(in_mask),
        .out_valid(out_valid), .out_result(out_result)
    );

    // Behavioural reference: bit queues, no shared structure with the RTL.
    function automatic logic [W-1:0] model(input logic [1:0] op,
                                           input logic [W-1:0] s,
                                           input logic [W-1:0] m);
        logic [W-1:0] r;
        bit hi_q[$];
        bit lo_q[$];
        int k;
        r = '0;
        k = 0;
        case (op)
            2'b00: begin  // R1
                for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
            end
            2'b01: begin  // R2
                for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
            end
            2'b10: begin  // R3
                for (int i = 0; i < W; i++) begin
                    if (m[i]) hi_q.push_back(s[i]); else lo_q.push_back(s[i]);
                end
                for (int j = 0; j < lo_q.size(); j++) r[j] = lo_q[j];
                for (int j = 0; j < hi_q.size(); j++) r[W - hi_q.size() + j] = hi_q[j];
            end
            default: r = '0;  // R6
        endcase
        return r;
    endfunction

    function automatic string tag_for(input logic v, input logic [1:0] op,
                                      input logic [W-1:0] m);
        if (!v) return "R9";
        if (m == '0) return "R4";
        if (&m) return "R5";
        case (op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R6";
        endcase
    endfunction

    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_result = '0;
    string        exp_tag = "R8";
    bit           armed = 1'b0;
    bit           was_rst = 1'b0;

    always @(posedge clk) begin
        armed <= 1'b1;
        was_rst <= rst;
        if (rst) begin
            exp_valid  <= 1'b0;
            exp_result <= '0;
            exp_tag    <= "R8";
        end else begin
            exp_valid <= in_valid;
            if (in_valid) exp_result <= model(in_op, in_src, in_mask);
            exp_tag <= tag_for(in_valid, in_op, in_mask);
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (out_valid !== exp_valid) begin
                errors++;
                $display("FAIL %s: out_valid got %b expected %b",
                         was_rst ? "R8" : "R7", out_valid, exp_valid);
            end
            checks++;
            if (out_result !== exp_result) begin
                errors++;
                $display("FAIL %s: out_result got %h expected %h",
                         exp_tag, out_result, exp_result);
            end
        end
    end

    task automatic drive(input logic v, input logic [1:0] op,
                         input logic [W-1:0] s, input logic [W-1:0] m);
        @(negedge clk);
        in_valid = v;
        in_op    = op;
        in_src   = s;
        in_mask  = m;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 gather: alternating nibble mask, contiguous mask, sparse mask
        drive(1, 2'b00, 64'hF0F0_1234_ABCD_5678, 64'h0F0F_0F0F_0F0F_0F0F);
        drive(1, 2'b00, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0FF0_0000_0000);
        drive(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0001_0000_8001);
        // R2 scatter: upper source bits must be ignored
        drive(1, 2'b01, 64'hFFFF_FFFF_FFFF_FF05, 64'h8100_0000_0000_0081);
        drive(1, 2'b01, 64'h0000_0000_0000_00A5, 64'hF000_0000_0000_000F);
        drive(1, 2'b01, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_AAAA_5555_5555);
        // R3 split
        drive(1, 2'b10, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_FFFF_0000);
        drive(1, 2'b10, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001);
        drive(1, 2'b10, 64'hFEDC_BA98_7654_3210, 64'h5A5A_5A5A_A5A5_A5A5);
        // R4 zero mask, R5 full mask
        for (int op = 0; op < 3; op++) drive(1, op[1:0], 64'h0F1E_2D3C_4B5A_6978, '0);
        for (int op = 0; op < 3; op++) drive(1, op[1:0], 64'h0F1E_2D3C_4B5A_6978, '1);
        // R6 reserved
        drive(1, 2'b11, 64'hFFFF_0000_FFFF_0000, 64'h1234_0000_0000_4321);
        // R9 idle with changing inputs
        drive(1, 2'b00, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0F0F);
        drive(0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(0, 2'b11, 64'h1111_2222_3333_4444, 64'h0);
        // Random back-to-back traffic, R7 timing on every cycle
        for (int n = 0; n < 400; n++) begin
            drive(($urandom % 4) != 0, 2'($urandom), {$urandom, $urandom},
                  ((n % 3) == 0) ? ({$urandom, $urandom} & {$urandom, $urandom})
                                 : {$urandom, $urandom});
        end
        // R8 reset in the middle of traffic
        drive(1, 2'b10, 64'hAAAA_5555_AAAA_5555, 64'h00FF_00FF_00FF_00FF);
        @(negedge clk);
        rst = 1'b1;
        drive(1, 2'b00, 64'h1, 64'h1);
        drive(0, 2'b00, '0, '0);
        rst = 1'b0;
        drive(1, 2'b01, 64'h3, 64'h0000_0000_0000_0300);
        drive(0, 2'b00, '0, '0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule